// File: doc/BRIEF.md
# Cartridge Bank-Switching Register File

This block sits between a console's CPU write bus and the cartridge's program (PRG) and character (CHR) ROM address lines. CPU writes in the upper half of the address space load a small set of bank registers: a control byte, eleven bank data registers and a mirroring bit. From that state the block turns the CPU address into a 5-bit PRG bank number for the current 8 KiB window. It turns PPU address bits A12..A10 into an 8-bit CHR bank number for the current 1 KiB window. It also drives the nametable RAM page line from PPU A10 or A11.

The outputs are combinational from the stored registers and the present addresses. A register write takes effect on the clock edge on which `cpu_wr` is sampled high, and it is visible on the outputs after that edge. The write port is a plain strobe with no back-pressure: the block accepts a write on every cycle, and no data leaves it as a stream.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the control byte, all bank registers and the mirroring bit are zero. Every PRG window except `$E000` then outputs bank 0, every CHR window outputs bank 0, and `ciram_a10` follows PPU A10.
- R2: A write acts only when `cpu_addr[15]`=1. `cpu_addr[14:13]` picks the register pair (0=`$8000`, 1=`$A000`, 2=`$C000`, 3=`$E000`), and `cpu_addr[0]` picks the even (0) or odd (1) member. Other address bits are ignored. Writes below `$8000`, odd writes to `$A000-$BFFF` and any write to `$C000-$FFFF` change no output.
- R3: An even write to `$8000-$9FFF` loads the control byte. Bit 7 is CHR half inversion C, bit 6 is PRG order P, bit 5 is fine-CHR mode K, and bits 3:0 are the target index.
- R4: An odd write to `$8000-$9FFF` stores all 8 data bits into bank register [index] when the index is 0-9 or 15. Indices 10-14 leave every register unchanged.
- R5: With P=0, windows `$8000`, `$A000` and `$C000` output the low 5 bits of R6, R7 and R15 in that order.
- R6: With P=1, windows `$8000`, `$A000` and `$C000` output the low 5 bits of R15, R6 and R7 in that order.
- R7: Window `$E000-$FFFF` (`cpu_addr[14:13]`=3) always outputs bank 31.
- R8: With K=0 and C=0, PPU `$0000-$07FF` uses R0 and `$0800-$0FFF` uses R1, each with bit 0 replaced by PPU A10. PPU `$1000`, `$1400`, `$1800` and `$1C00` use R2, R3, R4 and R5.
- R9: With K=1 and C=0, the eight 1 KiB windows from `$0000` upward use R0, R8, R1, R9, R2, R3, R4 and R5, with all 8 bits passed through.
- R10: C=1 gives the same CHR lookup with PPU A12 inverted, so the two 4 KiB halves swap.
- R11: An even write to `$A000-$BFFF` sets the mirroring bit from data bit 0. With 0, `ciram_a10` = PPU A10 (vertical). With 1, `ciram_a10` = PPU A11 (horizontal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address, used for write decode and PRG window select |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising clock edge |
| ppu_addr_hi | input | 3 | PPU address bits A12, A11, A10 (bit 2 = A12) |
| prg_bank | output | 5 | 8 KiB PRG bank for the window in `cpu_addr[14:13]` |
| chr_bank | output | 8 | 1 KiB CHR bank for the window in `ppu_addr_hi` |
| ciram_a10 | output | 1 | Nametable RAM page select |

## Verification
Every bank register is first loaded with a distinct value, and the PRG registers carry nonzero upper bits, so any wrong register choice or a missing 5-bit truncation shows up as a wrong number. The lookup is then swept across all four combinations of the CHR mode bits and both PRG orders. Each sweep reaches every window, so a rotation confused with a swap, an A10 substitution left out, or an A12 inversion applied to the wrong half each give a distinct mismatch. Directed writes to index 10-14 and to addresses outside the decoded pairs then confirm that the register contents, as read back through the lookups, do not move. The mirroring bit is toggled, and an odd write to its pair is applied, to confirm that the nametable page line switches between A10 and A11.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int CPU_AW    = 16;
  localparam int DW        = 8;
  localparam int PRG_W     = 5;
  localparam int CHR_W     = 8;
  localparam int NUM_SLOTS = 16;
  localparam int IDX_W     = $clog2(NUM_SLOTS);

  typedef struct packed {
    logic             chr_inv;
    logic             prg_rot;
    logic             chr_fine;
    logic             spare;
    logic [IDX_W-1:0] idx;
  } ctrl_t;

  function automatic logic slot_exists(input int i);
    return (i <= 9) || (i == 15);
  endfunction
endpackage

// File: rtl/cbm_regfile.sv
module cbm_regfile
  import cbm_pkg::*;
#(
  parameter int AW = CPU_AW,
  parameter int W  = DW
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               addr,
  input  logic [W-1:0]                data,
  output ctrl_t                       ctrl_o,
  output logic [NUM_SLOTS-1:0][W-1:0] banks_o,
  output logic                        mirror_o
);
  logic       in_win;
  logic [1:0] pair;
  logic       odd;
  logic       ctrl_we, data_we, mir_we;
  ctrl_t      ctrl_q;
  logic       mirror_q;
  logic       unused_addr_bits;

  assign in_win  = addr[AW-1];
  assign pair    = addr[AW-2:AW-3];
  assign odd     = addr[0];
  assign ctrl_we = wr_en && in_win && (pair == 2'd0) && !odd;
  assign data_we = wr_en && in_win && (pair == 2'd0) && odd;
  assign mir_we  = wr_en && in_win && (pair == 2'd1) && !odd;
  assign unused_addr_bits = ^addr[AW-4:1];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mirror_q <= 1'b0;
    else if (mir_we) mirror_q <= data[0];
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (slot_exists(i)) begin : g_reg
      logic [W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else if (data_we && (ctrl_q.idx == IDX_W'(i))) val_q <= data;
      end
      assign banks_o[i] = val_q;
    end else begin : g_none
      assign banks_o[i] = '0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign mirror_o = mirror_q;

  assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_o == ctrl_t'($past(data))));

  assert_bad_index_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && (ctrl_q.idx >= 4'd10) && (ctrl_q.idx <= 4'd14)) |=> $stable(banks_o));

  assert_low_half_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr[AW-1]) |=> ($stable(banks_o) && $stable(ctrl_o) && $stable(mirror_o)));

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> ((banks_o == '0) && (ctrl_o == '0) && !mirror_o));
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map
  import cbm_pkg::*;
#(
  parameter int W  = DW,
  parameter int BW = PRG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    win,
  input  logic          rot,
  input  logic [W-1:0]  r6,
  input  logic [W-1:0]  r7,
  input  logic [W-1:0]  r15,
  output logic [BW-1:0] bank_o
);
  localparam logic [BW-1:0] LAST_BANK = '1;
  logic unused_hi_bits;

  assign unused_hi_bits = ^{r6[W-1:BW], r7[W-1:BW], r15[W-1:BW]};

  always_comb begin
    unique case (win)
      2'd0:    bank_o = rot ? r15[BW-1:0] : r6[BW-1:0];
      2'd1:    bank_o = rot ? r6[BW-1:0]  : r7[BW-1:0];
      2'd2:    bank_o = rot ? r7[BW-1:0]  : r15[BW-1:0];
      default: bank_o = LAST_BANK;
    endcase
  end

  assert_top_window_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win == 2'd3) |-> (bank_o == LAST_BANK));

  assert_rotation_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rot && win == 2'd1) |-> (bank_o == r6[BW-1:0]));
endmodule

// File: rtl/cbm_chr_map.sv
module cbm_chr_map
  import cbm_pkg::*;
#(
  parameter int BW = CHR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          ppu_hi,
  input  logic                inv,
  input  logic                fine,
  input  logic [7:0][BW-1:0]  slots,
  output logic [BW-1:0]       bank_o
);
  logic       pair_half;
  logic [2:0] pick;
  logic       a10;

  assign a10       = ppu_hi[0];
  assign pair_half = !(ppu_hi[2] ^ inv);

  always_comb begin
    if (!pair_half)
      pick = {1'b1, ppu_hi[1:0]};
    else if (fine)
      pick = {1'b0, ppu_hi[1:0]};
    else
      pick = {1'b0, ppu_hi[1], 1'b0};
  end

  always_comb begin
    bank_o = slots[pick];
    if (pair_half && !fine) bank_o[0] = a10;
  end

  assert_wide_bank_low_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_half && !fine) |-> (bank_o[0] == ppu_hi[0]));

  assert_fine_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_half && fine) |-> (bank_o == slots[{1'b0, ppu_hi[1:0]}]));
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_data,
  input  logic              cpu_wr,
  input  logic [2:0]        ppu_addr_hi,
  output logic [PRG_W-1:0]  prg_bank,
  output logic [CHR_W-1:0]  chr_bank,
  output logic              ciram_a10
);
  ctrl_t                        ctrl;
  logic [NUM_SLOTS-1:0][DW-1:0] banks;
  logic                         mirror;
  logic [7:0][CHR_W-1:0]        chr_slots;
  logic                         unused_slots;

  assign unused_slots = ^{banks[14:10], ctrl.spare};

  cbm_regfile #(.AW(CPU_AW), .W(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .addr(cpu_addr), .data(cpu_data),
    .ctrl_o(ctrl), .banks_o(banks), .mirror_o(mirror)
  );

  cbm_prg_map #(.W(DW), .BW(PRG_W)) u_prg (
    .clk(clk), .rst_n(rst_n), .win(cpu_addr[CPU_AW-2:CPU_AW-3]), .rot(ctrl.prg_rot),
    .r6(banks[6]), .r7(banks[7]), .r15(banks[15]), .bank_o(prg_bank)
  );

  // slot order: paired half by {A11,A10}, then the 1 KiB half
  assign chr_slots = {banks[5][CHR_W-1:0], banks[4][CHR_W-1:0],
                      banks[3][CHR_W-1:0], banks[2][CHR_W-1:0],
                      banks[9][CHR_W-1:0], banks[1][CHR_W-1:0],
                      banks[8][CHR_W-1:0], banks[0][CHR_W-1:0]};

  cbm_chr_map #(.BW(CHR_W)) u_chr (
    .clk(clk), .rst_n(rst_n), .ppu_hi(ppu_addr_hi), .inv(ctrl.chr_inv),
    .fine(ctrl.chr_fine), .slots(chr_slots), .bank_o(chr_bank)
  );

  assign ciram_a10 = mirror ? ppu_addr_hi[1] : ppu_addr_hi[0];

  assert_vertical_page_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mirror |-> (ciram_a10 == ppu_addr_hi[0]));
endmodule

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic [2:0]  ppu_addr_hi = '0;
  logic [4:0]  prg_bank;
  logic [7:0]  chr_bank;
  logic        ciram_a10;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  cart_bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr_hi(ppu_addr_hi), .prg_bank(prg_bank),
    .chr_bank(chr_bank), .ciram_a10(ciram_a10)
  );

  // {ctrl[7:0], window[1:0], ppu[2:0], prg[4:0], chr[7:0]}
  localparam int NV = 25;
  localparam logic [25:0] VEC [NV] = '{
    {8'h00, 2'd0, 3'd0, 5'd6,  8'h10}, {8'h00, 2'd1, 3'd1, 5'd7,  8'h11},
    {8'h00, 2'd2, 3'd2, 5'd15, 8'h20}, {8'h00, 2'd3, 3'd3, 5'd31, 8'h21},
    {8'h00, 2'd0, 3'd4, 5'd6,  8'h32}, {8'h00, 2'd1, 3'd5, 5'd7,  8'h43},
    {8'h00, 2'd2, 3'd6, 5'd15, 8'h54}, {8'h00, 2'd3, 3'd7, 5'd31, 8'h65},
    {8'h40, 2'd0, 3'd0, 5'd15, 8'h10}, {8'h40, 2'd1, 3'd4, 5'd6,  8'h32},
    {8'h40, 2'd2, 3'd7, 5'd7,  8'h65}, {8'h40, 2'd3, 3'd1, 5'd31, 8'h11},
    {8'h20, 2'd0, 3'd0, 5'd6,  8'h10}, {8'h20, 2'd1, 3'd1, 5'd7,  8'h88},
    {8'h20, 2'd2, 3'd2, 5'd15, 8'h21}, {8'h20, 2'd3, 3'd3, 5'd31, 8'h99},
    {8'h20, 2'd0, 3'd5, 5'd6,  8'h43},
    {8'h80, 2'd0, 3'd0, 5'd6,  8'h32}, {8'h80, 2'd1, 3'd3, 5'd7,  8'h65},
    {8'h80, 2'd2, 3'd4, 5'd15, 8'h10}, {8'h80, 2'd3, 3'd7, 5'd31, 8'h21},
    {8'hE0, 2'd0, 3'd1, 5'd15, 8'h43}, {8'hE0, 2'd1, 3'd5, 5'd6,  8'h88},
    {8'hE0, 2'd2, 3'd7, 5'd7,  8'h99}, {8'hE0, 2'd3, 3'd6, 5'd31, 8'h21}
  };

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic load_bank(input int idx, input logic [7:0] d);
    wr(16'h8000, 8'(idx));
    wr(16'h8001, d);
  endtask

  task automatic look(input logic [1:0] win, input logic [2:0] ppu);
    cpu_addr = {1'b1, win, 13'h0};
    ppu_addr_hi = ppu;
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    look(2'd0, 3'd0); chk("R1 prg", prg_bank, 0); chk("R1 chr", chr_bank, 0);
    look(2'd3, 3'd5); chk("R1 prg top", prg_bank, 31); chk("R1 chr", chr_bank, 0);
    look(2'd1, 3'd1); chk("R1 ciram", ciram_a10, 1);

    // R4 load implemented slots with distinct values
    load_bank(0, 8'h10); load_bank(1, 8'h21); load_bank(2, 8'h32);
    load_bank(3, 8'h43); load_bank(4, 8'h54); load_bank(5, 8'h65);
    load_bank(6, 8'hE6); load_bank(7, 8'h27); load_bank(8, 8'h88);
    load_bank(9, 8'h99); load_bank(15, 8'hCF);

    // R3 R5 R6 R7 R8 R9 R10 table sweep
    for (int i = 0; i < NV; i++) begin
      wr(16'h8000, VEC[i][25:18]);
      look(VEC[i][17:16], VEC[i][15:13]);
      chk("R5/R6/R7 prg lookup", prg_bank, VEC[i][12:8]);
      chk("R8/R9/R10 chr lookup", chr_bank, VEC[i][7:0]);
    end

    // R4 indices 10..14 ignored
    for (int k = 10; k < 15; k++) load_bank(k, 8'hFF);
    wr(16'h8000, 8'h20);
    for (int p = 0; p < 8; p++) begin
      look(2'd0, 3'(p));
      chk("R4 ignored index chr", chr_bank,
          (p == 0) ? 8'h10 : (p == 1) ? 8'h88 : (p == 2) ? 8'h21 : (p == 3) ? 8'h99 :
          (p == 4) ? 8'h32 : (p == 5) ? 8'h43 : (p == 6) ? 8'h54 : 8'h65);
    end
    look(2'd0, 3'd0); chk("R4 ignored index prg6", prg_bank, 6);
    look(2'd1, 3'd0); chk("R4 ignored index prg7", prg_bank, 7);
    look(2'd2, 3'd0); chk("R4 ignored index prg15", prg_bank, 15);

    // R2 writes outside the decoded registers
    wr(16'h0000, 8'h00);   // would clear control
    wr(16'h0001, 8'h77);   // would hit slot 0
    wr(16'h2000, 8'h01);   // would set mirroring
    wr(16'hA001, 8'h01);   // odd member of mirroring pair
    wr(16'hC000, 8'h40);
    wr(16'hE001, 8'h01);
    look(2'd0, 3'd1); chk("R2 control kept", chr_bank, 8'h88);
    look(2'd0, 3'd0); chk("R2 slot0 kept", chr_bank, 8'h10);
    look(2'd0, 3'd2); chk("R2 mirroring kept", ciram_a10, 0);

    // R11 mirroring
    wr(16'hA000, 8'hFF);
    look(2'd0, 3'd2); chk("R11 horizontal A11=1", ciram_a10, 1);
    look(2'd0, 3'd1); chk("R11 horizontal A10=1", ciram_a10, 0);
    wr(16'hBFFE, 8'hFE);
    look(2'd0, 3'd2); chk("R11 vertical A11=1", ciram_a10, 0);
    look(2'd0, 3'd1); chk("R11 vertical A10=1", ciram_a10, 1);

    // R3 wide decode: odd address high in the pair still reaches data port
    wr(16'h9FFE, 8'h00);
    wr(16'h9FFF, 8'h5A);
    look(2'd0, 3'd0); chk("R3 index 0 via mirror address", chr_bank, 8'h5A);
    look(2'd0, 3'd1); chk("R8 A10 substitution", chr_bank, 8'h5B);

    // R1 reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(2'd2, 3'd6); chk("R1 prg after reset", prg_bank, 0);
    chk("R1 chr after reset", chr_bank, 0);
    look(2'd0, 3'd2); chk("R1 ciram after reset", ciram_a10, 0);

    summary();
  end
endmodule